// File: doc/BRIEF.md
# Saturating Multiply-Add Pipeline

This block is a signed multiply-add datapath. It multiplies several signed operand pairs and adds the products into one full-width sum. It can also fold in its own previous sum as an accumulator, and it can add a full-width chain input from a neighbouring stage. A bit field of that total is then selected, optionally rounded, and passed through a saturation unit. The unit can wrap, clamp symmetrically or clamp to the full two's-complement range. A flag marks every clamped result.

Parameters select each pipeline stage: operand inputs, multiplier outputs, adder output and output. Two modes force a stage on. Accumulation needs the adder register, and shift-in needs the operand register. In shift-in mode the A operands form a tapped delay line, and the last tap is brought out, optionally through one more register. A clock enable and a user clear can be used or left unused. When both clears are in use, the user clear is combined with the global clear. Rounding without saturation, operand counts outside 4 to 8, and field positions that do not fit the sum are all rejected at elaboration.

Top module: `sat_muladd`

## Requirements
- R1: The sum is computed modulo 2^SUM_W. It is the sum over all pairs of signed A_i times signed B_i, plus signed `chain_in` when CHAIN_EN=1. With CHAIN_EN=0 the chain input has no effect. `chain_out` carries this sum.
- R2: `result` is bits [OUT_MSB:OUT_LSB] of the sum, taken after an arithmetic right shift by OUT_LSB. With ROUND_EN=1, 2^(OUT_LSB-1) is added before the shift (round half up). Otherwise the low bits are dropped.
- R3: With SAT_MODE=0 (wrap), `result` is the low OW bits of the shifted value, and `clamped` stays 0.
- R4: With SAT_MODE=1 (symmetric), values above 2^(OW-1)-1 become 2^(OW-1)-1. Values below -(2^(OW-1)-1) become -(2^(OW-1)-1). The code with only the sign bit set never appears.
- R5: With SAT_MODE=2 (asymmetric), the limits are 2^(OW-1)-1 and -2^(OW-1).
- R6: `clamped` is 1 exactly when the saturation unit replaced the value by a limit. It appears in the same cycle as that `result`.
- R7: Operand latency is IN_REG (forced by SHIFT_IN) + MUL_REG + ADD_REG (forced by ACCUM_EN) + OUT_REG clock-enabled edges. `chain_in` enters after the adder register.
- R8: With USE_ENA=1, an edge with `ena`=0 leaves every register unchanged. With USE_ENA=0, `ena` has no effect.
- R9: With ACCUM_EN=1, each enabled edge loads the adder register with its previous value plus the new sum of products, modulo 2^SUM_W.
- R10: With SHIFT_IN=1, pair 0 takes A from `a_in` bits [AW-1:0], and pair i>0 takes the registered A of pair i-1. The other `a_in` bits are ignored. `shift_out` is the registered A of the last pair, delayed one more edge when SHOUT_REG=1.
- R11: Every register clears asynchronously to 0. The clear source depends on the configuration:
  - USE_ACLR=1 and ACLR_OR_GLOBAL=1: `aclr` or `glob_clr` clears.
  - USE_ACLR=1 and ACLR_OR_GLOBAL=0: only `aclr` clears, and `glob_clr` is ignored.
  - USE_ACLR=0: only `glob_clr` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| glob_clr | input | 1 | Global asynchronous clear, active high |
| aclr | input | 1 | User asynchronous clear, active high |
| ena | input | 1 | Clock enable for all register stages |
| a_in | input | PAIRS*AW | A operands, pair i in bits [i*AW +: AW] |
| b_in | input | PAIRS*BW | B operands, pair i in bits [i*BW +: BW] |
| chain_in | input | SUM_W | Signed sum from a neighbouring stage |
| result | output | OUT_MSB-OUT_LSB+1 | Rounded, saturated output field |
| clamped | output | 1 | Result was replaced by a saturation limit |
| chain_out | output | SUM_W | Full-width sum including chain input |
| shift_out | output | AW | Last tap of the A operand line |

## Verification
The bench runs three configurations, each checked on its own schedule:
- The fully registered symmetric one has random clock-enable gaps. Its result is compared on the falling edge after the fourth enabled rising edge that follows the operands, and its chain input is paired with the output edge.
- The unregistered asymmetric one is combinational. It is checked one nanosecond after each input change.
- The wrapping accumulator with shift-in has an input stage and an adder stage. Its result shows the accumulation two edges after an operand is applied. `shift_out` shows an operand three edges after it enters pair 0, one edge for each tap and one for the extra register.

Clear pulses are placed mid-sweep so that each configuration's clear combination shows at the next falling edge.

// File: rtl/sat_muladd.sv
module sat_muladd #(
  parameter int PAIRS = 2,
  parameter int AW = 4,
  parameter int BW = 4,
  parameter int SUM_W = 10,
  parameter int OUT_LSB = 2,
  parameter int OUT_MSB = 6,
  parameter int SAT_MODE = 1,
  parameter bit ROUND_EN = 1,
  parameter bit ACCUM_EN = 0,
  parameter bit SHIFT_IN = 0,
  parameter bit CHAIN_EN = 1,
  parameter bit IN_REG = 1,
  parameter bit MUL_REG = 1,
  parameter bit ADD_REG = 1,
  parameter bit OUT_REG = 1,
  parameter bit SHOUT_REG = 0,
  parameter bit USE_ENA = 1,
  parameter bit USE_ACLR = 1,
  parameter bit ACLR_OR_GLOBAL = 1
) (
  input  logic                       clk,
  input  logic                       glob_clr,
  input  logic                       aclr,
  input  logic                       ena,
  input  logic [PAIRS*AW-1:0]        a_in,
  input  logic [PAIRS*BW-1:0]        b_in,
  input  logic [SUM_W-1:0]           chain_in,
  output logic [OUT_MSB-OUT_LSB:0]   result,
  output logic                       clamped,
  output logic [SUM_W-1:0]           chain_out,
  output logic [AW-1:0]              shift_out
);
  localparam int PW = AW + BW;
  localparam int OW = OUT_MSB - OUT_LSB + 1;
  localparam int RW = SUM_W + 1 - OUT_LSB;
  localparam bit IN_R = IN_REG || SHIFT_IN;
  localparam bit ADD_R = ADD_REG || ACCUM_EN;
  localparam logic signed [SUM_W:0] RND = ROUND_EN ? (SUM_W+1)'(1 << (OUT_LSB - 1)) : '0;
  localparam logic signed [RW-1:0] HI = RW'((1 << (OW - 1)) - 1);
  localparam logic signed [RW-1:0] LO = (SAT_MODE == 2) ? -HI - 1 : -HI;

  if (ROUND_EN && SAT_MODE == 0) begin : g_err_round
    $error("sat_muladd: rounding requires a saturating mode");
  end
  if (2*PAIRS < 4 || 2*PAIRS > 8) begin : g_err_pairs
    $error("sat_muladd: operand count must be 4 to 8");
  end
  if (OUT_MSB >= SUM_W || OUT_LSB < (ROUND_EN ? 1 : 0) || OUT_MSB <= OUT_LSB || SUM_W <= PW) begin : g_err_field
    $error("sat_muladd: output field does not fit the sum");
  end

  logic clr_i, ce;
  assign clr_i = USE_ACLR ? (aclr | (ACLR_OR_GLOBAL & glob_clr)) : glob_clr;
  assign ce = !USE_ENA || ena;

  logic [PAIRS-1:0][AW-1:0] a_src, a_s;
  logic [PAIRS-1:0][BW-1:0] b_s;
  logic [PAIRS-1:0][PW-1:0] p_c, p_s;
  logic [SUM_W-1:0] acc_fb, sum_c, add_s, csum;

  always_comb begin
    a_src = a_in;
    if (SHIFT_IN)
      for (int i = 1; i < PAIRS; i++) a_src[i] = a_s[i-1];
  end

  if (IN_R) begin : g_in_r
    always_ff @(posedge clk or posedge clr_i)
      if (clr_i) begin
        a_s <= '0;
        b_s <= '0;
      end else if (ce) begin
        a_s <= a_src;
        b_s <= b_in;
      end
  end else begin : g_in_c
    assign a_s = a_src;
    assign b_s = b_in;
  end

  always_comb
    for (int i = 0; i < PAIRS; i++) p_c[i] = PW'($signed(a_s[i]) * $signed(b_s[i]));

  if (MUL_REG) begin : g_mul_r
    always_ff @(posedge clk or posedge clr_i)
      if (clr_i) p_s <= '0;
      else if (ce) p_s <= p_c;
  end else begin : g_mul_c
    assign p_s = p_c;
  end

  if (ACCUM_EN) begin : g_acc
    assign acc_fb = add_s;
  end else begin : g_noacc
    assign acc_fb = '0;
  end

  always_comb begin
    sum_c = acc_fb;
    for (int i = 0; i < PAIRS; i++) sum_c = sum_c + SUM_W'($signed(p_s[i]));
  end

  if (ADD_R) begin : g_add_r
    always_ff @(posedge clk or posedge clr_i)
      if (clr_i) add_s <= '0;
      else if (ce) add_s <= sum_c;
  end else begin : g_add_c
    assign add_s = sum_c;
  end

  assign csum = add_s + (CHAIN_EN ? chain_in : '0);

  logic signed [RW-1:0] sh;
  logic hi_x, lo_x;
  logic [OW-1:0] sat_v;
  assign sh = RW'(($signed({csum[SUM_W-1], csum}) + RND) >>> OUT_LSB);
  assign hi_x = (SAT_MODE != 0) && (sh > HI);
  assign lo_x = (SAT_MODE != 0) && (sh < LO);
  assign sat_v = hi_x ? HI[OW-1:0] : lo_x ? LO[OW-1:0] : sh[OW-1:0];

  if (OUT_REG) begin : g_out_r
    always_ff @(posedge clk or posedge clr_i)
      if (clr_i) begin
        result <= '0;
        clamped <= 1'b0;
        chain_out <= '0;
      end else if (ce) begin
        result <= sat_v;
        clamped <= hi_x | lo_x;
        chain_out <= csum;
      end
  end else begin : g_out_c
    assign result = sat_v;
    assign clamped = hi_x | lo_x;
    assign chain_out = csum;
  end

  if (SHOUT_REG) begin : g_sho_r
    always_ff @(posedge clk or posedge clr_i)
      if (clr_i) shift_out <= '0;
      else if (ce) shift_out <= a_s[PAIRS-1];
  end else begin : g_sho_c
    assign shift_out = a_s[PAIRS-1];
  end
endmodule

module sat_muladd_chk #(
  parameter int SAT_MODE = 1,
  parameter int OW = 5,
  parameter bit OUT_REG = 1,
  parameter bit HOLD = 1
) (
  input logic          clk,
  input logic          clr,
  input logic          ena,
  input logic [OW-1:0] result,
  input logic          clamped
);
  localparam logic [OW-1:0] MINC = {1'b1, {(OW-1){1'b0}}};
  localparam logic [OW-1:0] HIC = {1'b0, {(OW-1){1'b1}}};
  localparam logic [OW-1:0] LOC = (SAT_MODE == 2) ? MINC : MINC + 1'b1;

  p_sym_floor_r4: assert property (@(posedge clk) disable iff (clr)
    (SAT_MODE == 1) |-> (result != MINC));
  p_no_clamp_wrap_r3: assert property (@(posedge clk) disable iff (clr)
    (SAT_MODE == 0) |-> !clamped);
  p_clamp_limit_r6: assert property (@(posedge clk) disable iff (clr)
    clamped |-> (result == HIC || result == LOC));
  p_hold_r8: assert property (@(posedge clk) disable iff (clr)
    (HOLD && !ena) |=> ($stable(result) && $stable(clamped)));

  always @(posedge clk)
    if (OUT_REG && clr)
      p_cleared_r11: assert (result == '0 && !clamped);
endmodule

bind sat_muladd sat_muladd_chk #(
  .SAT_MODE(SAT_MODE), .OW(OUT_MSB - OUT_LSB + 1), .OUT_REG(OUT_REG), .HOLD(USE_ENA && OUT_REG)
) u_chk (.clk(clk), .clr(clr_i), .ena(ena), .result(result), .clamped(clamped));

// File: tb/test_sat_muladd.sv
module test_sat_muladd;
  logic clk = 1'b0;
  logic glob_clr = 1'b1;
  logic aclr = 1'b1;
  logic ena = 1'b1;
  logic [7:0] a_in = '0;
  logic [7:0] b_in = '0;
  logic [9:0] chain_in = '0;
  logic [4:0] res_a, res_b, res_c;
  logic ov_a, ov_b, ov_c;
  logic [9:0] co_a, co_b, co_c;
  logic [3:0] so_a, so_b, so_c;

  always #5 clk = ~clk;

  sat_muladd #(.SAT_MODE(1), .ROUND_EN(1)) i_sat_muladd (
    .clk(clk), .glob_clr(glob_clr), .aclr(aclr), .ena(ena), .a_in(a_in), .b_in(b_in),
    .chain_in(chain_in), .result(res_a), .clamped(ov_a), .chain_out(co_a), .shift_out(so_a));

  sat_muladd #(.SAT_MODE(2), .ROUND_EN(0), .IN_REG(0), .MUL_REG(0), .ADD_REG(0), .OUT_REG(0),
    .USE_ENA(0), .USE_ACLR(0)) i_sat_muladd_b (
    .clk(clk), .glob_clr(glob_clr), .aclr(aclr), .ena(ena), .a_in(a_in), .b_in(b_in),
    .chain_in(chain_in), .result(res_b), .clamped(ov_b), .chain_out(co_b), .shift_out(so_b));

  sat_muladd #(.SAT_MODE(0), .ROUND_EN(0), .ACCUM_EN(1), .SHIFT_IN(1), .CHAIN_EN(0), .IN_REG(0),
    .MUL_REG(0), .ADD_REG(0), .OUT_REG(0), .SHOUT_REG(1), .USE_ENA(0), .USE_ACLR(1),
    .ACLR_OR_GLOBAL(0)) i_sat_muladd_c (
    .clk(clk), .glob_clr(glob_clr), .aclr(aclr), .ena(ena), .a_in(a_in), .b_in(b_in),
    .chain_in(chain_in), .result(res_c), .clamped(ov_c), .chain_out(co_c), .shift_out(so_c));

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int w10(input int x);
    return ((x + 512) & 1023) - 512;
  endfunction

  function automatic int sx4(input logic [3:0] v);
    return int'($signed(v));
  endfunction

  task automatic sat_ref(input int v, input int mode, input bit rnd, output int r, output int ov);
    int s;
    s = (rnd ? v + 2 : v) >>> 2;
    ov = 0;
    if (mode == 0) r = ((s + 16) & 31) - 16;
    else if (s > 15) begin r = 15; ov = 1; end
    else if (s < ((mode == 2) ? -16 : -15)) begin r = (mode == 2) ? -16 : -15; ov = 1; end
    else r = s;
  endtask

  // model state
  int a_in_s, a_mul, a_add, a_out, a_ov;
  int c_aq0, c_aq1, c_bq0, c_bq1, c_acc, c_sho;

  initial begin
    logic [15:0] lf;
    int a0, a1, b0, b1, ops, chv, r, o, s;
    bit g, u;
    lf = 16'hACE1;
    a_in_s = 0; a_mul = 0; a_add = 0; a_out = 0; a_ov = 0;
    c_aq0 = 0; c_aq1 = 0; c_bq0 = 0; c_bq1 = 0; c_acc = 0; c_sho = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset result A", int'(res_a), 0);
    chk("R11 reset clamped A", int'(ov_a), 0);
    chk("R11 reset result C", int'(res_c), 0);
    chk("R11 reset shift_out C", int'(so_c), 0);
    glob_clr = 1'b0;
    aclr = 1'b0;
    for (int c = 0; c < 65536; c++) begin
      @(negedge clk);
      chk("R7 R2 R4 result A", int'($signed(res_a)), a_out);
      chk("R6 R8 clamped A", int'(ov_a), a_ov);
      s = ((c_acc >>> 2) + 16 & 31) - 16;
      chk("R9 R3 result C", int'($signed(res_c)), s);
      chk("R3 clamped C", int'(ov_c), 0);
      chk("R10 shift_out C", sx4(so_c), c_sho);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a_in = c[7:0];
      b_in = c[15:8];
      chain_in = {{4{lf[5]}}, lf[5:0]};
      ena = (lf[9:8] != 2'b00);
      g = (c == 30000);
      u = (c == 50000);
      glob_clr = g;
      aclr = u;
      a0 = sx4(a_in[3:0]); a1 = sx4(a_in[7:4]);
      b0 = sx4(b_in[3:0]); b1 = sx4(b_in[7:4]);
      ops = a0 * b0 + a1 * b1;
      chv = int'($signed(lf[5:0]));
      #1;
      sat_ref(w10(ops + chv), 2, 0, r, o);
      chk("R1 R5 result B", int'($signed(res_b)), r);
      chk("R6 clamped B", int'(ov_b), o);
      chk("R1 chain_out B", int'($signed(co_b)), w10(ops + chv));
      if (g || u) begin
        a_in_s = 0; a_mul = 0; a_add = 0; a_out = 0; a_ov = 0;
      end else if (ena) begin
        sat_ref(w10(a_add + chv), 1, 1, r, o);
        a_out = r; a_ov = o;
        a_add = a_mul; a_mul = a_in_s; a_in_s = w10(ops);
      end
      if (u) begin
        c_aq0 = 0; c_aq1 = 0; c_bq0 = 0; c_bq1 = 0; c_acc = 0; c_sho = 0;
      end else begin
        c_acc = w10(c_acc + c_aq0 * c_bq0 + c_aq1 * c_bq1);
        c_sho = c_aq1;
        c_aq1 = c_aq0;
        c_aq0 = a0;
        c_bq0 = b0;
        c_bq1 = b1;
      end
    end
    @(negedge clk);
    chk("R7 final result A", int'($signed(res_a)), a_out);
    chk("R9 final result C", int'($signed(res_c)), ((c_acc >>> 2) + 16 & 31) - 16);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule